// File: doc/BRIEF.md
# Microsequencer with Opcode Dispatch

This block produces the micro-address and the control word for a small microcoded processor control unit. The control store is held inside the block. Every microword drives the datapath: it names which register drives the internal bus, which registers capture the bus, the ALU function and the memory command. It also carries the address of the word that follows. Routines normally walk through consecutive words. The last word of each instruction routine points back to the first fetch step.

The fetch routine takes three words. The third word, which loads the instruction register from the memory buffer, carries a dispatch flag. On that word the next address comes from a 16-entry table indexed by the 4-bit opcode of the instruction being loaded, and the next-address field is not used. No separate decode step is needed. A word whose memory command is "wait" holds the sequencer until the memory reports ready.

The datapath sits outside this block. It presents the opcode field of the word on its bus as `opcode_in`, and it reports completion of the previous memory operation on `mem_ready`. The address and every control field are registered outputs that change together, one clock after the sequencer decides the next address.

Top module: `usequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) makes `uaddr` 0 after that edge and presents the first fetch word.
- R2: Fetch step 1, at address 0, outputs bus_src=1 (PC), load_en=8'hA0 (MAR in bit 5, ALU input in bit 7), alu_fn=3 (increment) and mem_fn=1 (read).
- R3: Fetch step 2, at address 1, outputs bus_src=3 (result), load_en=8'h02 (PC in bit 1), alu_fn=0 and mem_fn=3 (wait).
- R4: Fetch step 3, at address 2, outputs bus_src=6 (MBR), load_en=8'h01 (IR in bit 0), alu_fn=0 and mem_fn=0.
- R5: Without a dispatch or a hold, the next address is the microword's next-address field. Within a routine this is the following address, and address 0 is followed by 1, then 2.
- R6: After address 2, the next address comes from the opcode table. Opcode 1 (subtract R1 by memory at R2 plus address field) maps to 16, opcode 2 (add R2 to R1) to 24, opcode 3 (jump) to 28 and opcode 4 (load R1 from memory) to 32. Every other opcode maps to the one-step no-op routine at 8.
- R7: The last words of the routines (8, 21, 26, 28 and 34) are followed by address 0.
- R8: While the current word has mem_fn=3 (wait: addresses 1, 19 and 33) and `mem_ready` is low, `uaddr` and all control outputs hold. With `mem_ready` high, the sequencer moves to the following address.
- R9: `opcode_in` has no effect on any step other than address 2.
- R10: `mem_ready` has no effect on steps whose mem_fn is not wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_ready | input | 1 | Previous memory operation has completed |
| opcode_in | input | 4 | Opcode field of the instruction on the bus |
| uaddr | output | 6 | Current micro-address |
| bus_src | output | 3 | Bus driver: 0 none, 1 PC, 2 IR address field, 3 result, 4 R1, 5 R2, 6 MBR |
| load_en | output | 8 | Bus capture enables: IR, PC, operand, R1, R2, MAR, MBR, ALU input (bits 0 to 7) |
| alu_fn | output | 3 | ALU function: 0 none, 1 add, 2 subtract, 3 increment, 4 decrement |
| mem_fn | output | 2 | Memory command: 0 idle, 1 read, 2 write, 3 wait |

## Verification
The bench checks long and repeated memory stalls on all three wait words. A sequencer that ignored the stall would skip the MBR transfer. One that held on the wrong condition would hang or freeze outside a wait step. The opcode input changes on every cycle, so a design that dispatched on the wrong step, or took the table entry on ordinary steps, would jump away from its routine. Every table entry reached, including the default no-op, is compared against the route expected, and a reset in the middle of a routine must return the sequencer straight to the first fetch word.

// File: rtl/usequencer_pkg.sv
package usequencer_pkg;
  localparam int UADDR_W = 6;
  localparam int OPC_W   = 4;
  localparam int LD_W    = 8;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0, SRC_PC = 3'd1, SRC_IRADR = 3'd2, SRC_RES = 3'd3,
    SRC_R1 = 3'd4, SRC_R2 = 3'd5, SRC_MBR = 3'd6
  } src_e;

  typedef enum logic [2:0] {
    ALU_NONE = 3'd0, ALU_ADD = 3'd1, ALU_SUB = 3'd2, ALU_INC = 3'd3, ALU_DEC = 3'd4
  } alu_e;

  typedef enum logic [1:0] {
    MEM_IDLE = 2'd0, MEM_READ = 2'd1, MEM_WRITE = 2'd2, MEM_WAIT = 2'd3
  } mem_e;

  localparam int LD_IR = 0, LD_PC = 1, LD_OPD = 2, LD_R1 = 3;
  localparam int LD_R2 = 4, LD_MAR = 5, LD_MBR = 6, LD_ALU = 7;

  typedef struct packed {
    src_e                 src;
    logic [LD_W-1:0]      ld;
    alu_e                 alu;
    mem_e                 mem;
    logic                 disp;
    logic [UADDR_W-1:0]   nxt;
  } uword_t;

  localparam int WORD_W = $bits(uword_t);

  // Routine entry points
  localparam int A_FETCH = 0;
  localparam int A_NOP   = 8;
  localparam int A_SUB   = 16;
  localparam int A_ADD   = 24;
  localparam int A_JMP   = 28;
  localparam int A_LDR   = 32;

  function automatic logic [LD_W-1:0] ldm(input int idx);
    logic [LD_W-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  function automatic uword_t mk(input src_e s, input logic [LD_W-1:0] l, input alu_e a,
                                input mem_e m, input logic d, input int n);
    uword_t w;
    w.src  = s;
    w.ld   = l;
    w.alu  = a;
    w.mem  = m;
    w.disp = d;
    w.nxt  = UADDR_W'(n);
    return w;
  endfunction

  // Control store contents
  function automatic uword_t ucode(input int a);
    case (a)
      0:  return mk(SRC_PC,    ldm(LD_MAR) | ldm(LD_ALU), ALU_INC,  MEM_READ, 1'b0, 1);
      1:  return mk(SRC_RES,   ldm(LD_PC),                ALU_NONE, MEM_WAIT, 1'b0, 2);
      2:  return mk(SRC_MBR,   ldm(LD_IR),                ALU_NONE, MEM_IDLE, 1'b1, A_FETCH);
      8:  return mk(SRC_NONE,  '0,                        ALU_NONE, MEM_IDLE, 1'b0, A_FETCH);
      16: return mk(SRC_R2,    ldm(LD_OPD),               ALU_NONE, MEM_IDLE, 1'b0, 17);
      17: return mk(SRC_IRADR, ldm(LD_ALU),               ALU_ADD,  MEM_IDLE, 1'b0, 18);
      18: return mk(SRC_RES,   ldm(LD_MAR),               ALU_NONE, MEM_READ, 1'b0, 19);
      19: return mk(SRC_R1,    ldm(LD_OPD),               ALU_NONE, MEM_WAIT, 1'b0, 20);
      20: return mk(SRC_MBR,   ldm(LD_ALU),               ALU_SUB,  MEM_IDLE, 1'b0, 21);
      21: return mk(SRC_RES,   ldm(LD_R1),                ALU_NONE, MEM_IDLE, 1'b0, A_FETCH);
      24: return mk(SRC_R2,    ldm(LD_OPD),               ALU_NONE, MEM_IDLE, 1'b0, 25);
      25: return mk(SRC_R1,    ldm(LD_ALU),               ALU_ADD,  MEM_IDLE, 1'b0, 26);
      26: return mk(SRC_RES,   ldm(LD_R1),                ALU_NONE, MEM_IDLE, 1'b0, A_FETCH);
      28: return mk(SRC_IRADR, ldm(LD_PC),                ALU_NONE, MEM_IDLE, 1'b0, A_FETCH);
      32: return mk(SRC_IRADR, ldm(LD_MAR),               ALU_NONE, MEM_READ, 1'b0, 33);
      33: return mk(SRC_NONE,  '0,                        ALU_NONE, MEM_WAIT, 1'b0, 34);
      34: return mk(SRC_MBR,   ldm(LD_R1),                ALU_NONE, MEM_IDLE, 1'b0, A_FETCH);
      default: return mk(SRC_NONE, '0, ALU_NONE, MEM_IDLE, 1'b0, A_FETCH);
    endcase
  endfunction

  // Opcode to routine map
  function automatic logic [UADDR_W-1:0] route(input int op);
    case (op)
      1:       return UADDR_W'(A_SUB);
      2:       return UADDR_W'(A_ADD);
      3:       return UADDR_W'(A_JMP);
      4:       return UADDR_W'(A_LDR);
      default: return UADDR_W'(A_NOP);
    endcase
  endfunction
endpackage

// File: rtl/usequencer_rom.sv
module usequencer_rom
  import usequencer_pkg::*;
#(
  parameter int AW = UADDR_W,
  parameter int W  = WORD_W
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [W-1:0]  q
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = W'(ucode(i));
  end

  always_ff @(posedge clk) begin
    q <= mem[addr];
  end
endmodule

// File: rtl/usequencer_dispatch.sv
module usequencer_dispatch
  import usequencer_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int AW = UADDR_W
) (
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] target
);
  localparam int NOPC = 1 << OW;

  logic [AW-1:0] tbl [NOPC];

  for (genvar g = 0; g < NOPC; g++) begin : g_tab
    assign tbl[g] = AW'(route(g));
  end

  assign target = tbl[opcode];
endmodule

// File: rtl/usequencer_next.sv
module usequencer_next
  import usequencer_pkg::*;
#(
  parameter int AW = UADDR_W
) (
  input  logic          rst,
  input  logic [AW-1:0] cur_addr,
  input  mem_e          cur_mem,
  input  logic          cur_disp,
  input  logic [AW-1:0] cur_nxt,
  input  logic          mem_ready,
  input  logic [AW-1:0] disp_target,
  output logic [AW-1:0] next_addr
);
  logic stall;

  assign stall = (cur_mem == MEM_WAIT) && !mem_ready;

  always_comb begin
    if (rst)           next_addr = '0;
    else if (stall)    next_addr = cur_addr;
    else if (cur_disp) next_addr = disp_target;
    else               next_addr = cur_nxt;
  end
endmodule

// File: rtl/usequencer.sv
module usequencer
  import usequencer_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               mem_ready,
  input  logic [OPC_W-1:0]   opcode_in,
  output logic [UADDR_W-1:0] uaddr,
  output logic [2:0]         bus_src,
  output logic [LD_W-1:0]    load_en,
  output logic [2:0]         alu_fn,
  output logic [1:0]         mem_fn
);
  logic [UADDR_W-1:0] addr_q;
  logic [UADDR_W-1:0] next_addr;
  logic [UADDR_W-1:0] disp_target;
  logic [WORD_W-1:0]  word_q;
  uword_t             cur;

  assign cur = uword_t'(word_q);

  usequencer_rom #(.AW(UADDR_W), .W(WORD_W)) u_rom (
    .clk  (clk),
    .addr (next_addr),
    .q    (word_q)
  );

  usequencer_dispatch #(.OW(OPC_W), .AW(UADDR_W)) u_dispatch (
    .opcode (opcode_in),
    .target (disp_target)
  );

  usequencer_next #(.AW(UADDR_W)) u_next (
    .rst         (rst),
    .cur_addr    (addr_q),
    .cur_mem     (cur.mem),
    .cur_disp    (cur.disp),
    .cur_nxt     (cur.nxt),
    .mem_ready   (mem_ready),
    .disp_target (disp_target),
    .next_addr   (next_addr)
  );

  always_ff @(posedge clk) begin
    addr_q <= next_addr;
  end

  assign uaddr   = addr_q;
  assign bus_src = cur.src;
  assign load_en = cur.ld;
  assign alu_fn  = cur.alu;
  assign mem_fn  = cur.mem;

  // R1: reset lands on the first fetch step
  p_reset_addr_r1: assert property (@(posedge clk) rst |=> uaddr == '0);

  // R2: first fetch word starts the memory read
  p_fetch_read_r2: assert property (@(posedge clk) disable iff (rst)
    (uaddr == '0) |-> (mem_fn == MEM_READ));

  // R5: fetch step 1 always moves to step 2
  p_fetch_step_r5: assert property (@(posedge clk) disable iff (rst)
    (uaddr == '0) |=> (uaddr == UADDR_W'(1)));

  // R6: the IR-load word never falls through sequentially
  p_dispatch_leaves_r6: assert property (@(posedge clk) disable iff (rst)
    load_en[LD_IR] |=> (uaddr != $past(uaddr) + UADDR_W'(1)));

  // R8: stalled wait word holds address and command
  p_wait_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_fn == MEM_WAIT && !mem_ready) |=> ($stable(uaddr) && $stable(load_en)));

  // R8: a completed wait lets the sequencer move on
  p_wait_release_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_fn == MEM_WAIT && mem_ready) |=> (uaddr != $past(uaddr)));
endmodule

// File: tb/usequencer_bench.sv
module usequencer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mem_ready = 1'b0;
  logic [3:0] opcode_in = 4'd0;
  logic [5:0] uaddr;
  logic [2:0] bus_src;
  logic [7:0] load_en;
  logic [2:0] alu_fn;
  logic [1:0] mem_fn;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  int    exp_addr = 0;
  string tag = "R1";
  bit    held = 1'b0;
  logic [15:0] saved_fields;

  always #4 clk = ~clk;

  usequencer u_usequencer (
    .clk(clk), .rst(rst), .mem_ready(mem_ready), .opcode_in(opcode_in),
    .uaddr(uaddr), .bus_src(bus_src), .load_en(load_en), .alu_fn(alu_fn), .mem_fn(mem_fn)
  );

  function automatic bit is_wait(input int a);
    return (a == 1) || (a == 19) || (a == 33);
  endfunction

  function automatic int model_next(input int a, input bit rdy, input int op);
    if (is_wait(a) && !rdy) return a;
    if (a == 2) begin
      case (op)
        1: return 16;
        2: return 24;
        3: return 28;
        4: return 32;
        default: return 8;
      endcase
    end
    if (a == 8 || a == 21 || a == 26 || a == 28 || a == 34) return 0;
    return a + 1;
  endfunction

  // {bus_src, load_en, alu_fn, mem_fn} for the fetch words
  function automatic logic [15:0] fetch_fields(input int a);
    case (a)
      0:       return {3'd1, 8'hA0, 3'd3, 2'd1};
      1:       return {3'd3, 8'h02, 3'd0, 2'd3};
      default: return {3'd6, 8'h01, 3'd0, 2'd0};
    endcase
  endfunction

  function automatic string fetch_tag(input int a);
    case (a)
      0:       return "R2";
      1:       return "R3";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    int nx;
    if (rst) begin
      exp_addr <= 0;
      tag      <= "R1";
      held     <= 1'b0;
    end else begin
      nx = model_next(exp_addr, mem_ready, int'(opcode_in));
      held <= is_wait(exp_addr) && !mem_ready;
      if (exp_addr == 2)                        tag <= "R6";
      else if (is_wait(exp_addr))               tag <= "R8";
      else if (nx == 0)                         tag <= "R7";
      else if (exp_addr == 0)                   tag <= "R5";
      else if (!mem_ready)                      tag <= "R10";
      else                                      tag <= "R9";
      exp_addr <= nx;
    end
  end

  always @(negedge clk) begin
    logic [15:0] f;
    if (checking) begin
      f = {bus_src, load_en, alu_fn, mem_fn};
      checks++;
      if (uaddr !== 6'(exp_addr)) begin
        errors++;
        $display("FAIL %s uaddr actual %0d expected %0d", tag, uaddr, exp_addr);
      end
      if (exp_addr <= 2) begin
        checks++;
        if (f !== fetch_fields(exp_addr)) begin
          errors++;
          $display("FAIL %s fields actual %h expected %h", fetch_tag(exp_addr), f,
                   fetch_fields(exp_addr));
        end
      end
      if (held) begin
        checks++;
        if (f !== saved_fields) begin
          errors++;
          $display("FAIL R8 held fields actual %h expected %h", f, saved_fields);
        end
      end
      saved_fields = f;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checking = 1'b1;
    // long stall on fetch step 2 while the opcode wanders (R8, R9)
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      opcode_in = 4'(c * 5);
    end
    mem_ready = 1'b1;
    // mixed stall and opcode patterns
    for (int c = 0; c < 900; c++) begin
      @(negedge clk);
      mem_ready = ((c % 5) != 0) && ((c % 7) != 3);
      opcode_in = 4'((c * 3 + c / 11) % 16);
    end
    // reset in the middle of a routine (R1)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      mem_ready = (c % 3) != 1;
      opcode_in = 4'(c % 6);
    end
    @(negedge clk);
    checking = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule